// File: doc/BRIEF.md
# I2C Interrupt Status and Clear-on-Read Unit

This unit gathers the event pulses of an I2C bus engine and the fill levels of its transmit and receive FIFOs into one 12-bit raw status word. A programmable enable mask selects which raw bits reach the masked status word, and one interrupt line goes high whenever any masked bit is set. The FIFO threshold comparators that produce the two level-type bits are part of this unit. The bus engine and the FIFOs are not.

Event bits are sticky. Software clears them by reading a dedicated clear address, one address per bit, or by reading a global clear address that removes every sticky bit at once. The two level bits follow the FIFO levels in the same cycle and take no software action. The unit also keeps the cause of a transmit abort, so software can find out why the engine gave up. The register port is a simple single-cycle read/write port. Read data is combinational from the address. A clear takes effect at the clock edge on which the read strobe is high.

Top module: `i2c_intr_ctl`

## Requirements
- R1: Raw status (address 1) places its bits as follows: receive underflow at bit 0, receive overflow at 1, receive threshold at 2, transmit overflow at 3, transmit threshold at 4, transmit abort at 6, activity at 8, stop seen at 9, start seen at 10, general call at 11. Bits 5, 7 and 12 upward read as 0.
- R2: The enable mask (address 0, bits 11:0) resets to 0x8FF. Masked status (address 2) equals raw AND mask. `irq` is high exactly when masked status is non-zero.
- R3: The transmit threshold bit is 1 while `tx_level` is at or below the effective transmit threshold. The receive threshold bit is 1 while `rx_level` is at or above the effective receive threshold. Both bits follow the levels in the same cycle.
- R4: The receive threshold is at address 3 and the transmit threshold at address 4. Both are TL_W bits wide, reset to 0 and read back as written. A value above FIFO_DEPTH acts as FIFO_DEPTH.
- R5: A one-cycle pulse on an event input sets its sticky bit at the next clock edge. The bit then stays set until a clear reaches it.
- R6: Each sticky bit has its own clear address: receive underflow 6, receive overflow 7, transmit overflow 8, transmit abort 9, activity 10, stop seen 11, start seen 12, general call 13. A read there clears only that bit.
- R7: A read of a clear address returns, in bit 0, the value the bit held before the clear, with all other bits 0. A read of the global clear address returns the OR of all sticky bits.
- R8: A read of the global clear address (5) clears every sticky bit and the abort cause. The two threshold bits are not affected.
- R9: While `bus_active` is high, a clear of the activity bit, by its own address or by the global clear, has no effect.
- R10: An event pulse in the same cycle as a clear read of its bit leaves the bit set.
- R11: On each transmit abort pulse, `abort_src` is ORed into the abort cause. The cause is visible on `abort_cause` and at address 14. A read of address 9 or of address 5 returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_rx_under | input | 1 | Pulse: receive FIFO read while it was empty |
| ev_rx_over | input | 1 | Pulse: received byte lost because the receive FIFO was full |
| ev_tx_over | input | 1 | Pulse: write to a full transmit FIFO |
| ev_tx_abrt | input | 1 | Pulse: transmit abort |
| ev_activity | input | 1 | Pulse: bus activity seen |
| ev_stop | input | 1 | Pulse: stop condition seen |
| ev_start | input | 1 | Pulse: start or repeated start seen |
| ev_gen_call | input | 1 | Pulse: general call acknowledged |
| abort_src | input | CAUSE_W | Abort reason bits, sampled with ev_tx_abrt |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| bus_active | input | 1 | Bus is busy |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; triggers clears |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from reg_addr |
| abort_cause | output | CAUSE_W | Accumulated abort reason |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the unit with FIFO_DEPTH = 8, so LVL_W is 4 and a level can reach the full depth. With that depth, a threshold of 200 exercises the clamp: the receive threshold bit then rises only at level 8, and the transmit threshold bit stays on even at level 8. The default TL_W of 8 and CAUSE_W of 17 are kept, so an abort cause such as 0x1234 fits and can be checked for accumulation.

// File: rtl/i2c_intr_pkg.sv
package i2c_intr_pkg;
   localparam int STAT_W = 12;

   localparam int B_RX_UNDER = 0;
   localparam int B_RX_OVER  = 1;
   localparam int B_RX_FULL  = 2;
   localparam int B_TX_OVER  = 3;
   localparam int B_TX_EMPTY = 4;
   localparam int B_TX_ABRT  = 6;
   localparam int B_ACTIVITY = 8;
   localparam int B_STOP     = 9;
   localparam int B_START    = 10;
   localparam int B_GEN_CALL = 11;

   localparam logic [STAT_W-1:0] STICKY_MASK = 12'hF4B;
   localparam logic [STAT_W-1:0] MASK_RST    = 12'h8FF;

   localparam int ADR_MASK    = 0;
   localparam int ADR_RAW     = 1;
   localparam int ADR_MASKED  = 2;
   localparam int ADR_RX_THR  = 3;
   localparam int ADR_TX_THR  = 4;
   localparam int ADR_CLR_ALL = 5;
   localparam int ADR_CAUSE   = 14;

   // Clear address of each sticky bit; 15 marks a bit without one.
   function automatic int clr_addr(input int b);
      case (b)
         B_RX_UNDER: return 6;
         B_RX_OVER:  return 7;
         B_TX_OVER:  return 8;
         B_TX_ABRT:  return 9;
         B_ACTIVITY: return 10;
         B_STOP:     return 11;
         B_START:    return 12;
         B_GEN_CALL: return 13;
         default:    return 15;
      endcase
   endfunction
endpackage

// File: rtl/i2c_intr_sticky.sv
module i2c_intr_sticky #(
   parameter bit BUSY_GATED = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic busy_i,
   output logic q_o
);
   logic clr_eff;

   generate
      if (BUSY_GATED) begin : g_gated
         assign clr_eff = clr_i & ~busy_i;
      end else begin : g_plain
         logic unused_busy;
         assign unused_busy = busy_i;
         assign clr_eff = clr_i;
      end
   endgenerate

   // A set in the same cycle as a clear wins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= set_i | (q_o & ~clr_eff);
   end
endmodule

// File: rtl/i2c_intr_level.sv
module i2c_intr_level #(
   parameter int FIFO_DEPTH  = 16,
   parameter int TL_W        = 8,
   parameter int LVL_W       = 5,
   parameter bit AT_OR_ABOVE = 1'b0
) (
   input  logic [TL_W-1:0]  thr_i,
   input  logic [LVL_W-1:0] lvl_i,
   output logic             hit_o
);
   localparam int CW = ((TL_W > LVL_W) ? TL_W : LVL_W) + 1;

   logic [CW-1:0] thr_w, lvl_w, thr_eff;

   assign thr_w   = CW'(thr_i);
   assign lvl_w   = CW'(lvl_i);
   assign thr_eff = (thr_w > CW'(FIFO_DEPTH)) ? CW'(FIFO_DEPTH) : thr_w;

   generate
      if (AT_OR_ABOVE) begin : g_above
         assign hit_o = (lvl_w >= thr_eff);
      end else begin : g_below
         assign hit_o = (lvl_w <= thr_eff);
      end
   endgenerate
endmodule

// File: rtl/i2c_intr_regs.sv
module i2c_intr_regs
   import i2c_intr_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 32,
   parameter int TL_W    = 8,
   parameter int CAUSE_W = 17
) (
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_rd,
   input  logic               reg_wr,
   input  logic [STAT_W-1:0]  raw_i,
   input  logic [STAT_W-1:0]  mask_i,
   input  logic [TL_W-1:0]    rx_thr_i,
   input  logic [TL_W-1:0]    tx_thr_i,
   input  logic [CAUSE_W-1:0] cause_i,
   output logic [DATA_W-1:0]  rdata_o,
   output logic [STAT_W-1:0]  clr_one_o,
   output logic               clr_all_o,
   output logic               mask_we_o,
   output logic               rx_thr_we_o,
   output logic               tx_thr_we_o
);
   assign clr_all_o   = reg_rd & (reg_addr == ADDR_W'(ADR_CLR_ALL));
   assign mask_we_o   = reg_wr & (reg_addr == ADDR_W'(ADR_MASK));
   assign rx_thr_we_o = reg_wr & (reg_addr == ADDR_W'(ADR_RX_THR));
   assign tx_thr_we_o = reg_wr & (reg_addr == ADDR_W'(ADR_TX_THR));

   always_comb begin
      clr_one_o = '0;
      for (int b = 0; b < STAT_W; b++) begin
         if (STICKY_MASK[b] && (reg_addr == ADDR_W'(clr_addr(b))))
            clr_one_o[b] = reg_rd;
      end
   end

   always_comb begin
      rdata_o = '0;
      if (reg_addr == ADDR_W'(ADR_MASK))         rdata_o = DATA_W'(mask_i);
      else if (reg_addr == ADDR_W'(ADR_RAW))     rdata_o = DATA_W'(raw_i);
      else if (reg_addr == ADDR_W'(ADR_MASKED))  rdata_o = DATA_W'(raw_i & mask_i);
      else if (reg_addr == ADDR_W'(ADR_RX_THR))  rdata_o = DATA_W'(rx_thr_i);
      else if (reg_addr == ADDR_W'(ADR_TX_THR))  rdata_o = DATA_W'(tx_thr_i);
      else if (reg_addr == ADDR_W'(ADR_CLR_ALL)) rdata_o = DATA_W'(|(raw_i & STICKY_MASK));
      else if (reg_addr == ADDR_W'(ADR_CAUSE))   rdata_o = DATA_W'(cause_i);
      else begin
         for (int b = 0; b < STAT_W; b++) begin
            if (STICKY_MASK[b] && (reg_addr == ADDR_W'(clr_addr(b))))
               rdata_o = DATA_W'(raw_i[b]);
         end
      end
   end
endmodule

// File: rtl/i2c_intr_ctl.sv
module i2c_intr_ctl
   import i2c_intr_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int TL_W       = 8,
   parameter int CAUSE_W    = 17,
   parameter int ADDR_W     = 4,
   parameter int DATA_W     = 32,
   parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ev_rx_under,
   input  logic               ev_rx_over,
   input  logic               ev_tx_over,
   input  logic               ev_tx_abrt,
   input  logic               ev_activity,
   input  logic               ev_stop,
   input  logic               ev_start,
   input  logic               ev_gen_call,
   input  logic [CAUSE_W-1:0] abort_src,
   input  logic [LVL_W-1:0]   tx_level,
   input  logic [LVL_W-1:0]   rx_level,
   input  logic               bus_active,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic [CAUSE_W-1:0] abort_cause,
   output logic               irq
);
   generate
      if (FIFO_DEPTH < 2)            begin : g_e0 $error("FIFO_DEPTH must be at least 2"); end
      if (ADDR_W < 4)                begin : g_e1 $error("ADDR_W must be at least 4"); end
      if (DATA_W <= STAT_W)          begin : g_e2 $error("DATA_W must exceed the status width"); end
      if (TL_W > STAT_W)             begin : g_e3 $error("TL_W must not exceed the status width"); end
      if ((1 << TL_W) <= FIFO_DEPTH) begin : g_e4 $error("TL_W too narrow for FIFO_DEPTH"); end
      if (CAUSE_W > DATA_W)          begin : g_e5 $error("CAUSE_W must fit in DATA_W"); end
      if (LVL_W < $clog2(FIFO_DEPTH + 1)) begin : g_e6 $error("LVL_W too narrow"); end
   endgenerate

   logic [STAT_W-1:0]  raw_stat, ev_vec, clr_one, mask_q;
   logic [TL_W-1:0]    rx_thr_q, tx_thr_q;
   logic [CAUSE_W-1:0] cause_q, cause_d;
   logic               clr_all, mask_we, rx_thr_we, tx_thr_we;
   logic               tx_hit, rx_hit;
   logic               unused_wdata;

   assign unused_wdata = ^reg_wdata[DATA_W-1:STAT_W];

   always_comb begin
      ev_vec             = '0;
      ev_vec[B_RX_UNDER] = ev_rx_under;
      ev_vec[B_RX_OVER]  = ev_rx_over;
      ev_vec[B_TX_OVER]  = ev_tx_over;
      ev_vec[B_TX_ABRT]  = ev_tx_abrt;
      ev_vec[B_ACTIVITY] = ev_activity;
      ev_vec[B_STOP]     = ev_stop;
      ev_vec[B_START]    = ev_start;
      ev_vec[B_GEN_CALL] = ev_gen_call;
   end

   i2c_intr_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TL_W(TL_W), .CAUSE_W(CAUSE_W)
   ) u_regs (
      .reg_addr   (reg_addr),
      .reg_rd     (reg_rd),
      .reg_wr     (reg_wr),
      .raw_i      (raw_stat),
      .mask_i     (mask_q),
      .rx_thr_i   (rx_thr_q),
      .tx_thr_i   (tx_thr_q),
      .cause_i    (cause_q),
      .rdata_o    (reg_rdata),
      .clr_one_o  (clr_one),
      .clr_all_o  (clr_all),
      .mask_we_o  (mask_we),
      .rx_thr_we_o(rx_thr_we),
      .tx_thr_we_o(tx_thr_we)
   );

   i2c_intr_level #(
      .FIFO_DEPTH(FIFO_DEPTH), .TL_W(TL_W), .LVL_W(LVL_W), .AT_OR_ABOVE(1'b0)
   ) u_tx_cmp (.thr_i(tx_thr_q), .lvl_i(tx_level), .hit_o(tx_hit));

   i2c_intr_level #(
      .FIFO_DEPTH(FIFO_DEPTH), .TL_W(TL_W), .LVL_W(LVL_W), .AT_OR_ABOVE(1'b1)
   ) u_rx_cmp (.thr_i(rx_thr_q), .lvl_i(rx_level), .hit_o(rx_hit));

   generate
      for (genvar b = 0; b < STAT_W; b++) begin : g_bit
         if (STICKY_MASK[b]) begin : g_sticky
            i2c_intr_sticky #(.BUSY_GATED(b == B_ACTIVITY)) u_bit (
               .clk   (clk),
               .rst_n (rst_n),
               .set_i (ev_vec[b]),
               .clr_i (clr_one[b] | clr_all),
               .busy_i(bus_active),
               .q_o   (raw_stat[b])
            );
         end else begin : g_other
            logic unused_b;
            assign unused_b = ev_vec[b] ^ clr_one[b];
            if (b == B_TX_EMPTY) begin : g_tx
               assign raw_stat[b] = tx_hit;
            end else if (b == B_RX_FULL) begin : g_rx
               assign raw_stat[b] = rx_hit;
            end else begin : g_zero
               assign raw_stat[b] = 1'b0;
            end
         end
      end
   endgenerate

   always_comb begin
      cause_d = (clr_all | clr_one[B_TX_ABRT]) ? '0 : cause_q;
      if (ev_tx_abrt) cause_d = cause_d | abort_src;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q   <= MASK_RST;
         rx_thr_q <= '0;
         tx_thr_q <= '0;
         cause_q  <= '0;
      end else begin
         if (mask_we)   mask_q   <= reg_wdata[STAT_W-1:0];
         if (rx_thr_we) rx_thr_q <= reg_wdata[TL_W-1:0];
         if (tx_thr_we) tx_thr_q <= reg_wdata[TL_W-1:0];
         cause_q <= cause_d;
      end
   end

   assign abort_cause = cause_q;
   assign irq         = |(raw_stat & mask_q);
endmodule

// File: rtl/i2c_intr_ctl_chk.sv
module i2c_intr_ctl_chk #(
   parameter int LVL_W   = 5,
   parameter int CAUSE_W = 17,
   parameter int ADDR_W  = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ev_rx_over,
   input logic               ev_tx_abrt,
   input logic               ev_stop,
   input logic               bus_active,
   input logic [LVL_W-1:0]   tx_level,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic               reg_rd,
   input logic [CAUSE_W-1:0] abort_cause,
   input logic               irq,
   input logic [11:0]        raw
);
   logic rd_clr_all, rd_clr_rxo, rd_clr_act, rd_clr_stop;
   assign rd_clr_all  = reg_rd && (reg_addr == ADDR_W'(5));
   assign rd_clr_rxo  = reg_rd && (reg_addr == ADDR_W'(7));
   assign rd_clr_act  = reg_rd && (reg_addr == ADDR_W'(10));
   assign rd_clr_stop = reg_rd && (reg_addr == ADDR_W'(11));

   p_idle_no_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (raw == 12'h000) |-> !irq);
   p_tx_empty_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level == '0) |-> raw[4]);
   p_event_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rx_over |=> raw[1]);
   p_sticky_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (raw[1] && !rd_clr_rxo && !rd_clr_all) |=> raw[1]);
   p_clear_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr_rxo && !ev_rx_over) |=> !raw[1]);
   p_activity_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_clr_act || rd_clr_all) && bus_active && raw[8]) |=> raw[8]);
   p_coincide_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_stop && rd_clr_stop) |=> raw[9]);
   p_cause_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr_all && !ev_tx_abrt) |=> (abort_cause == '0));
endmodule

bind i2c_intr_ctl i2c_intr_ctl_chk #(
   .LVL_W(LVL_W), .CAUSE_W(CAUSE_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ev_rx_over (ev_rx_over),
   .ev_tx_abrt (ev_tx_abrt),
   .ev_stop    (ev_stop),
   .bus_active (bus_active),
   .tx_level   (tx_level),
   .reg_addr   (reg_addr),
   .reg_rd     (reg_rd),
   .abort_cause(abort_cause),
   .irq        (irq),
   .raw        (raw_stat)
);

// File: tb/i2c_intr_ctl_bench.sv
`timescale 1ns/1ps
module i2c_intr_ctl_bench;
   localparam int FIFO_DEPTH = 8;
   localparam int TL_W       = 8;
   localparam int CAUSE_W    = 17;
   localparam int ADDR_W     = 4;
   localparam int DATA_W     = 32;
   localparam int LVL_W      = $clog2(FIFO_DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_rx_under = 0, ev_rx_over = 0, ev_tx_over = 0, ev_tx_abrt = 0;
   logic ev_activity = 0, ev_stop = 0, ev_start = 0, ev_gen_call = 0;
   logic [CAUSE_W-1:0] abort_src = '0;
   logic [LVL_W-1:0]   tx_level = '0, rx_level = '0;
   logic               bus_active = 1'b0;
   logic [ADDR_W-1:0]  reg_addr = '0;
   logic               reg_wr = 1'b0, reg_rd = 1'b0;
   logic [DATA_W-1:0]  reg_wdata = '0;
   logic [DATA_W-1:0]  reg_rdata;
   logic [CAUSE_W-1:0] abort_cause;
   logic               irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   i2c_intr_ctl #(
      .FIFO_DEPTH(FIFO_DEPTH), .TL_W(TL_W), .CAUSE_W(CAUSE_W),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W)
   ) u_i2c_intr_ctl (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = ADDR_W'(a);
      reg_rd   = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_addr  = ADDR_W'(a);
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic set_ev(input int pos, input logic v);
      case (pos)
         0:  ev_rx_under = v;
         1:  ev_rx_over  = v;
         3:  ev_tx_over  = v;
         6:  ev_tx_abrt  = v;
         8:  ev_activity = v;
         9:  ev_stop     = v;
         10: ev_start    = v;
         11: ev_gen_call = v;
         default: ;
      endcase
   endtask

   task automatic pulse(input int pos);
      @(negedge clk);
      set_ev(pos, 1'b1);
      @(negedge clk);
      set_ev(pos, 1'b0);
   endtask

   task automatic levels(input int tx, input int rx);
      @(negedge clk);
      tx_level = LVL_W'(tx);
      rx_level = LVL_W'(rx);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(1, d);  chk("R1 reset raw (both level bits on)", d, 32'h14);
      rd(0, d);  chk("R2 reset mask", d, 32'h8FF);
      chk("R2 reset irq", {31'b0, irq}, 32'h1);
      rd(3, d);  chk("R4 reset rx threshold", d, 32'h0);
      chk("R11 reset abort cause", 32'(abort_cause), 32'h0);
   endtask

   task automatic t_levels;
      logic [31:0] d;
      wr(4, 3);
      levels(3, 0); rd(1, d); chk("R3 tx level equal to threshold", d & 32'h10, 32'h10);
      levels(4, 0); rd(1, d); chk("R3 tx level above threshold", d & 32'h10, 32'h0);
      wr(3, 5);
      levels(4, 4); rd(1, d); chk("R3 rx level below threshold", d & 32'h4, 32'h0);
      levels(4, 5); rd(1, d); chk("R3 rx level equal to threshold", d & 32'h4, 32'h4);
      wr(3, 200);
      rd(3, d); chk("R4 threshold reads back as written", d, 32'd200);
      levels(4, 7); rd(1, d); chk("R4 clamped rx threshold at depth-1", d & 32'h4, 32'h0);
      levels(4, 8); rd(1, d); chk("R4 clamped rx threshold at depth", d & 32'h4, 32'h4);
      wr(4, 200);
      levels(8, 0); rd(1, d); chk("R4 clamped tx threshold at full level", d & 32'h10, 32'h10);
      wr(4, 0); wr(3, 5);
      levels(4, 0); rd(1, d); chk("R3 quiet baseline", d, 32'h0);
      chk("R2 irq low when raw empty", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_sticky;
      int pos_list[8] = '{0, 1, 3, 6, 8, 9, 10, 11};
      int adr_list[8] = '{6, 7, 8, 9, 10, 11, 12, 13};
      logic [31:0] d;
      for (int i = 0; i < 8; i++) begin
         pulse(pos_list[i]);
         rd(1, d); chk("R1 R5 event sets its bit", d, 32'h1 << pos_list[i]);
         chk("R2 irq follows mask", {31'b0, irq}, (32'h8FF >> pos_list[i]) & 32'h1);
         rd(1, d); chk("R5 bit stays set", d, 32'h1 << pos_list[i]);
         rd(adr_list[i], d); chk("R7 clear read returns prior value", d, 32'h1);
         rd(1, d); chk("R6 clear address clears bit", d, 32'h0);
         rd(adr_list[i], d); chk("R7 second clear read returns 0", d, 32'h0);
      end
      wr(4, 0);
   endtask

   task automatic t_mask;
      logic [31:0] d;
      wr(0, 32'h002);
      pulse(0); pulse(1);
      rd(1, d); chk("R1 two sticky bits", d, 32'h3);
      rd(2, d); chk("R2 masked status", d, 32'h2);
      chk("R2 irq with enabled bit set", {31'b0, irq}, 32'h1);
      rd(7, d);
      rd(6, d); chk("R6 other bit untouched by neighbour clear", d, 32'h1);
      wr(0, 32'h001);
      rd(2, d); chk("R6 masked after both clears", d, 32'h0);
      chk("R2 irq low after masked bit cleared", {31'b0, irq}, 32'h0);
      wr(0, 32'h8FF);
   endtask

   task automatic t_global;
      logic [31:0] d;
      levels(4, 5);
      pulse(0); pulse(3); pulse(11);
      @(negedge clk); abort_src = 17'h1234;
      pulse(6);
      @(negedge clk); abort_src = '0;
      rd(1, d); chk("R1 mixed raw word", d, 32'h84D);
      rd(14, d); chk("R11 abort cause captured", d, 32'h1234);
      rd(5, d); chk("R7 global clear returns OR of sticky bits", d, 32'h1);
      rd(1, d); chk("R8 global clear keeps level bit", d, 32'h4);
      chk("R8 global clear clears abort cause", 32'(abort_cause), 32'h0);
      levels(4, 0);
   endtask

   task automatic t_activity;
      logic [31:0] d;
      @(negedge clk); bus_active = 1'b1;
      pulse(8);
      rd(10, d); chk("R7 activity clear read value", d, 32'h1);
      rd(1, d); chk("R9 activity kept while bus busy", d, 32'h100);
      rd(5, d);
      rd(1, d); chk("R9 global clear ignored for activity while busy", d, 32'h100);
      @(negedge clk); bus_active = 1'b0;
      rd(10, d);
      rd(1, d); chk("R9 activity cleared once bus idle", d, 32'h0);
   endtask

   task automatic t_coincide;
      logic [31:0] d;
      @(negedge clk);
      ev_stop  = 1'b1;
      reg_addr = ADDR_W'(11);
      reg_rd   = 1'b1;
      #1 d = reg_rdata;
      chk("R7 clear read before event lands", d, 32'h0);
      @(negedge clk);
      ev_stop = 1'b0;
      reg_rd  = 1'b0;
      rd(1, d); chk("R10 event wins over coincident clear", d, 32'h200);
      rd(11, d); chk("R10 bit then clears normally", d, 32'h1);
   endtask

   task automatic t_cause;
      logic [31:0] d;
      @(negedge clk); abort_src = 17'h00001;
      pulse(6);
      @(negedge clk); abort_src = 17'h00010;
      pulse(6);
      @(negedge clk); abort_src = '0;
      chk("R11 cause accumulates on port", 32'(abort_cause), 32'h11);
      rd(14, d); chk("R11 cause register", d, 32'h11);
      rd(9, d); chk("R7 abort clear read value", d, 32'h1);
      chk("R11 abort clear resets cause", 32'(abort_cause), 32'h0);
      rd(1, d); chk("R6 abort bit cleared", d, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_levels();
      t_sticky();
      t_mask();
      t_global();
      t_activity();
      t_coincide();
      t_cause();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule